// File: doc/BRIEF.md
# Synchronous Flow-Through Burst SRAM

This block is a cycle-accurate, synthesizable model of a single-clock synchronous static RAM. Its read path is flow-through. Address, write data and every control input are captured on the rising clock edge. The word held at the captured address then appears on the output during the cycle that follows, with no output register in between. A write is carried out entirely at the edge that captures it. No separate write strobe is needed.

A burst begins when one of two address strobes is asserted while all three chip enables are high. One strobe serves a processor and the other serves a cache controller. After the start, the address is produced inside the block from the captured base and a two-bit count. That count moves forward only in cycles where the advance input is high. The mode input chooses between two orders for the low two address bits, linear or interleaved. The upper address bits stay fixed for the whole burst.

Writes can cover any subset of the four byte lanes. A global write input forces all four lanes to be written. When a strobe arrives while any chip enable is low, the device is deselected after a single edge and raises a deselect flag.

Top module: `sram_fts`

## Requirements
- R1: While reset is held, and until a strobe with all chip enables high arrives, `desel` is 1 and `dout` is 0. While `desel` is 1, `dout` is always 0.
- R2: When `strb_cpu` is high and `ce_a`, `ce_b` and `ce_c` are all 1 at an edge, a read burst starts at `addr`. During the following cycle `dout` shows the word at `addr`, and the write inputs have no effect.
- R3: When `strb_cache` starts a burst and `we_all` is 1, all four lanes of `din` are written at `addr`, whatever `we_bytes` and `we_lane` are. `dout` reads 0 in any cycle that follows a write edge.
- R4: A write with `we_all` at 0 stores byte lane i (bits 8i+7..8i) only where `we_bytes` is 1 and `we_lane[i]` is 1. When `we_bytes` is 0, `we_lane` is ignored and the cycle is a read.
- R5: With `mode_linear` at 1, the low two address bits of burst step k are (start + k) mod 4.
- R6: With `mode_linear` at 0, the low two address bits of burst step k are start XOR k.
- R7: The burst count goes up by one only at an edge where `adv` is 1 and no strobe is high. Otherwise the same address is used again.
- R8: A strobe at an edge where any of `ce_a`, `ce_b`, `ce_c` is 0 deselects the device from the next cycle on. That edge writes nothing.
- R9: When both strobes are high together, the processor strobe wins. The cycle is a read and nothing is written.
- R10: Inside a burst, each cycle without a strobe is a write when the write inputs request one (R3, R4 rules) and a read otherwise. It acts on the current burst address.
- R11: The address bits above the low two stay at the start address for the whole burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Start address captured by a strobe |
| din | input | 32 | Write data |
| ce_a | input | 1 | Chip enable, active high |
| ce_b | input | 1 | Chip enable, active high |
| ce_c | input | 1 | Chip enable, active high |
| strb_cpu | input | 1 | Processor-side start strobe (read only) |
| strb_cache | input | 1 | Controller-side start strobe (samples write inputs) |
| adv | input | 1 | Burst count advance |
| mode_linear | input | 1 | 1 selects linear order, 0 interleaved |
| we_all | input | 1 | Global write, all lanes |
| we_bytes | input | 1 | Byte-write enable |
| we_lane | input | 4 | Per-lane write selects |
| dout | output | 32 | Flow-through read data, 0 when not reading |
| desel | output | 1 | Device deselected |

## Verification
The hardest case to reach is a write in the middle of a burst, at an address the block computed itself, in interleaved order and with only some lanes selected. To reach it, the bench starts bursts at unaligned bases in both orders. It mixes cycles with and without `adv`, and places partial byte writes inside the burst. It then reads the affected group back with new bursts. A behavioural reference array and burst model predicts `dout` and `desel` in every cycle. Strobe collisions, strobes with a write request on the processor side, and strobes with each chip enable dropped are also followed by reads that show whether anything was written.

// File: rtl/sram_fts_pkg.sv
package sram_fts_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } sram_op_e;

  // Low two address bits for burst step cnt from start bits base.
  function automatic logic [1:0] burst_low(input logic [1:0] base,
                                           input logic [1:0] cnt,
                                           input logic       linear);
    logic [1:0] r;
    if (linear) r = base + cnt;
    else        r = base ^ cnt;
    return r;
  endfunction

endpackage

// File: rtl/sram_fts_decode.sv
module sram_fts_decode
  import sram_fts_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             strb_cpu,
  input  logic             strb_cache,
  input  logic             ce_ok,
  input  logic             adv,
  input  logic             active_q,
  input  logic             we_all,
  input  logic             we_bytes,
  input  logic [LANES-1:0] we_lane,
  output logic             load,
  output logic             drop,
  output logic             step,
  output sram_op_e         op,
  output logic [LANES-1:0] lanes
);

  logic any_strb;
  logic wr_req;

  always_comb begin
    any_strb = strb_cpu | strb_cache;
    lanes    = we_all ? {LANES{1'b1}} : (we_bytes ? we_lane : '0);
    wr_req   = |lanes;
    load     = any_strb & ce_ok;
    drop     = any_strb & ~ce_ok;
    step     = ~any_strb & active_q & adv;
    op       = OP_IDLE;
    if (strb_cpu && ce_ok) begin
      op = OP_READ;                      // processor side never writes
    end else if (strb_cache && ce_ok) begin
      op = wr_req ? OP_WRITE : OP_READ;
    end else if (!any_strb && active_q) begin
      op = wr_req ? OP_WRITE : OP_READ;  // burst continuation
    end
  end

endmodule

// File: rtl/sram_fts_burst.sv
module sram_fts_burst
  import sram_fts_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              drop,
  input  logic              step,
  input  logic              linear,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              active_q,
  output logic [ADDR_W-1:0] nxt_addr,
  output logic [ADDR_W-1:0] addr_q
);

  localparam int HI_W = ADDR_W - 2;

  logic [ADDR_W-1:0] base_q, base_n;
  logic [1:0]        cnt_q, cnt_n;
  logic              active_n;
  logic              addr_en;

  // next-state
  always_comb begin
    base_n   = base_q;
    cnt_n    = cnt_q;
    active_n = active_q;
    if (load) begin
      base_n   = addr_in;
      cnt_n    = 2'd0;
      active_n = 1'b1;
    end else if (drop) begin
      active_n = 1'b0;
    end else if (step) begin
      cnt_n = cnt_q + 2'd1;
    end
    nxt_addr = {base_n[ADDR_W-1 -: HI_W], burst_low(base_n[1:0], cnt_n, linear)};
    addr_en  = load | active_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      addr_q   <= '0;
    end else begin
      base_q   <= base_n;
      cnt_q    <= cnt_n;
      active_q <= active_n;
      if (addr_en) addr_q <= nxt_addr;
    end
  end

endmodule

// File: rtl/sram_fts_array.sv
module sram_fts_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    wr,
  input  logic [LANES-1:0]        lanes,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic              lane_we;

    always_comb lane_we = wr & lanes[g];

    always_ff @(posedge clk) begin
      if (lane_we) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    always_comb rdata[g*LANE_W +: LANE_W] = mem[raddr];
  end

endmodule

// File: rtl/sram_fts.sv
module sram_fts
  import sram_fts_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic                    ce_a,
  input  logic                    ce_b,
  input  logic                    ce_c,
  input  logic                    strb_cpu,
  input  logic                    strb_cache,
  input  logic                    adv,
  input  logic                    mode_linear,
  input  logic                    we_all,
  input  logic                    we_bytes,
  input  logic [LANES-1:0]        we_lane,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    desel
);

  localparam int DATA_W = LANES * LANE_W;

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic              ce_ok;
  logic              load, drop, step;
  sram_op_e          op;
  logic [LANES-1:0]  lanes;
  logic              active_q;
  logic [ADDR_W-1:0] nxt_addr, addr_q;
  logic              rd_q, rd_n;
  logic [DATA_W-1:0] rdata;
  logic              wr;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  always_comb rst_sync_n = rst_pipe_q[1];

  always_comb ce_ok = ce_a & ce_b & ce_c;

  sram_fts_decode #(.LANES(LANES)) u_dec (
    .strb_cpu  (strb_cpu),
    .strb_cache(strb_cache),
    .ce_ok     (ce_ok),
    .adv       (adv),
    .active_q  (active_q),
    .we_all    (we_all),
    .we_bytes  (we_bytes),
    .we_lane   (we_lane),
    .load      (load),
    .drop      (drop),
    .step      (step),
    .op        (op),
    .lanes     (lanes)
  );

  sram_fts_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (load),
    .drop    (drop),
    .step    (step),
    .linear  (mode_linear),
    .addr_in (addr),
    .active_q(active_q),
    .nxt_addr(nxt_addr),
    .addr_q  (addr_q)
  );

  always_comb begin
    wr   = rst_sync_n & (op == OP_WRITE);
    rd_n = (op == OP_READ);
  end

  sram_fts_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk  (clk),
    .wr   (wr),
    .lanes(lanes),
    .waddr(nxt_addr),
    .wdata(din),
    .raddr(addr_q),
    .rdata(rdata)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rd_q <= 1'b0;
    else             rd_q <= rd_n;
  end

  // flow-through: array output gated straight to the port
  always_comb begin
    dout  = rd_q ? rdata : '0;
    desel = ~active_q;
  end

endmodule

// File: rtl/sram_fts_chk.sv
module sram_fts_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              ce_a,
  input logic              ce_b,
  input logic              ce_c,
  input logic              strb_cpu,
  input logic              strb_cache,
  input logic              adv,
  input logic              mode_linear,
  input logic [ADDR_W-1:0] addr_q,
  input logic [DATA_W-1:0] dout,
  input logic              desel
);

  logic all_ce;
  logic cont;
  always_comb begin
    all_ce = ce_a & ce_b & ce_c;
    cont   = ~desel & ~strb_cpu & ~strb_cache;
  end

  a_r1_quiet_out: assert property (@(posedge clk) disable iff (!rst_n)
    desel |-> dout == '0);

  a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ((strb_cpu || strb_cache) && !all_ce) |=> desel);

  a_r2_start_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_cpu && all_ce) |=> (!desel && addr_q == $past(addr)));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cont && !adv) |=> addr_q == $past(addr_q));

  a_r5_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cont && adv && mode_linear && $stable(mode_linear))
      |=> addr_q[1:0] == $past(addr_q[1:0]) + 2'd1);

  a_r11_upper: assert property (@(posedge clk) disable iff (!rst_n)
    cont |=> addr_q[ADDR_W-1:2] == $past(addr_q[ADDR_W-1:2]));

endmodule

bind sram_fts sram_fts_chk #(.ADDR_W(ADDR_W), .DATA_W(LANES*LANE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .addr       (addr),
  .ce_a       (ce_a),
  .ce_b       (ce_b),
  .ce_c       (ce_c),
  .strb_cpu   (strb_cpu),
  .strb_cache (strb_cache),
  .adv        (adv),
  .mode_linear(mode_linear),
  .addr_q     (addr_q),
  .dout       (dout),
  .desel      (desel)
);

// File: tb/sram_fts_test.sv
`timescale 1ns/1ps
module sram_fts_test;

  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic [31:0]   din;
  logic          ce_a, ce_b, ce_c;
  logic          strb_cpu, strb_cache, adv, mode_linear;
  logic          we_all, we_bytes;
  logic [3:0]    we_lane;
  logic [31:0]   dout;
  logic          desel;

  always #10 clk = ~clk;  // 50 MHz

  sram_fts uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
    .ce_a(ce_a), .ce_b(ce_b), .ce_c(ce_c),
    .strb_cpu(strb_cpu), .strb_cache(strb_cache), .adv(adv),
    .mode_linear(mode_linear), .we_all(we_all), .we_bytes(we_bytes),
    .we_lane(we_lane), .dout(dout), .desel(desel)
  );

  // reference model
  logic [31:0] ref_mem [DEPTH];
  bit          m_act;
  int          m_base, m_cnt;
  int          n_cmp, n_bad;
  bit          done;

  task automatic compare(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    strb_cpu = 0; strb_cache = 0; adv = 0; we_all = 0; we_bytes = 0;
    we_lane = 4'h0; ce_a = 1; ce_b = 1; ce_c = 1; addr = '0; din = '0;
  endtask

  // one clock: inputs already set; model advances with them, compared mid-cycle
  task automatic tick(input string tag);
    bit       ceok, any, wrq, is_rd, is_wr;
    int       a, lo;
    bit [3:0] ln;
    @(posedge clk);
    ceok = ce_a && ce_b && ce_c;
    any  = strb_cpu || strb_cache;
    ln   = we_all ? 4'hF : (we_bytes ? we_lane : 4'h0);
    wrq  = (ln != 0);
    is_rd = 0; is_wr = 0;
    if (strb_cpu && ceok) begin
      m_act = 1; m_base = int'(addr); m_cnt = 0; is_rd = 1;
    end else if (strb_cache && ceok) begin
      m_act = 1; m_base = int'(addr); m_cnt = 0; is_wr = wrq; is_rd = !wrq;
    end else if (any) begin
      m_act = 0;
    end else if (m_act) begin
      if (adv) m_cnt = (m_cnt + 1) % 4;
      is_wr = wrq; is_rd = !wrq;
    end
    lo = mode_linear ? ((m_base % 4) + m_cnt) % 4 : ((m_base % 4) ^ m_cnt);
    a  = (m_base / 4) * 4 + lo;
    if (is_wr)
      for (int i = 0; i < 4; i++)
        if (ln[i]) ref_mem[a][i*8 +: 8] = din[i*8 +: 8];
    @(negedge clk);
    compare({tag, " dout"}, dout, is_rd ? ref_mem[a] : 32'h0);
    compare({tag, " desel"}, {31'd0, desel}, {31'd0, !m_act});
  endtask

  task automatic burst_read(input string tag, input int base, input bit lin, input int beats);
    idle_inputs(); mode_linear = lin; strb_cpu = 1; addr = AW'(base);
    tick(tag);
    idle_inputs(); mode_linear = lin; adv = 1;
    for (int k = 1; k < beats; k++) tick(tag);
    idle_inputs(); mode_linear = lin;
  endtask

  initial begin
    idle_inputs(); mode_linear = 1; rst_n = 0;
    m_act = 0; m_base = 0; m_cnt = 0; n_cmp = 0; n_bad = 0; done = 0;
    repeat (3) @(negedge clk);
    // R1: held in reset
    compare("R1 reset dout", dout, 32'h0);
    compare("R1 reset desel", {31'd0, desel}, 32'd1);
    rst_n = 1;
    repeat (4) @(negedge clk);
    compare("R1 after release", {31'd0, desel}, 32'd1);
    tick("R1 idle");

    // R3: fill every word by cache strobe with global write (lanes selects garbage)
    for (int w = 0; w < DEPTH; w++) begin
      idle_inputs(); strb_cache = 1; we_all = 1; we_bytes = 0; we_lane = 4'h5;
      addr = AW'(w); din = 32'hA5000000 ^ (w * 32'h01010101) ^ (w << 4);
      tick("R3 fill");
    end
    idle_inputs();

    // R5 + R11: linear bursts from unaligned bases, wrap inside group
    burst_read("R5 linear base6", 6, 1, 4);
    burst_read("R5 linear base13", 13, 1, 6);
    // R6: interleaved
    burst_read("R6 interleave base5", 5, 0, 4);
    burst_read("R6 interleave base47", 47, 0, 5);

    // R7: hold without adv
    idle_inputs(); mode_linear = 1; strb_cpu = 1; addr = 6'd21; tick("R7 start");
    idle_inputs(); tick("R7 hold"); tick("R7 hold");
    adv = 1; tick("R7 step"); adv = 0; tick("R7 hold2");

    // R4 + R10: partial writes inside an interleaved burst
    idle_inputs(); mode_linear = 0; strb_cache = 1; addr = 6'd30;
    we_bytes = 1; we_lane = 4'b0110; din = 32'h11223344; tick("R4 start lanes");
    idle_inputs(); mode_linear = 0; adv = 1; we_bytes = 1; we_lane = 4'b1001;
    din = 32'hDEADBEEF; tick("R10 mid-burst write");
    idle_inputs(); mode_linear = 0; adv = 1; we_bytes = 0; we_lane = 4'hF;
    din = 32'hFFFFFFFF; tick("R4 lanes without enable");
    idle_inputs(); mode_linear = 0; adv = 1; we_all = 1; din = 32'hCAFEF00D;
    tick("R10 global mid-burst");
    burst_read("R10 readback", 28, 1, 4);

    // R2: processor strobe with write requests must read
    idle_inputs(); mode_linear = 1; strb_cpu = 1; addr = 6'd40; we_all = 1;
    din = 32'h0BADF00D; tick("R2 cpu ignores write");
    idle_inputs(); burst_read("R2 readback", 40, 1, 1);

    // R9: both strobes, processor wins, no write
    idle_inputs(); strb_cpu = 1; strb_cache = 1; addr = 6'd50; we_all = 1;
    din = 32'h99999999; tick("R9 both strobes");
    idle_inputs(); burst_read("R9 readback", 50, 1, 1);

    // R8: each chip enable dropped with a write strobe
    for (int c = 0; c < 3; c++) begin
      idle_inputs(); strb_cache = 1; we_all = 1; addr = AW'(60 + c);
      din = 32'h77777777;
      ce_a = (c != 0); ce_b = (c != 1); ce_c = (c != 2);
      tick("R8 deselect");
      idle_inputs(); tick("R8 stays deselected");
      burst_read("R8 no write", 60 + c, 1, 1);
    end

    // R1: deselected quiet output with activity on other inputs
    idle_inputs(); strb_cpu = 1; ce_b = 0; tick("R1 deselect");
    idle_inputs(); adv = 1; we_all = 1; din = 32'h12345678; tick("R1 quiet");
    idle_inputs(); burst_read("R1 no write while deselected", 0, 1, 4);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule